// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel RGB panel. It runs on the pixel clock. It counts pixels across each line and lines down each frame, and from those counts it drives the horizontal sync, vertical sync, data-enable, the coordinates of the current active pixel and a frame count. Inside the active window the pixel input passes through to the colour output. Outside the window a programmable blank colour is driven.

Software loads the geometry, the blank colour and a control word through a simple write port. Writes go into a staging copy. That copy moves into the working copy at the boundary between two frames. While the panel is off, it moves every cycle. Each frame opens with a sync pulse one pixel wide and one line wide. The back porch follows the sync pulse, then the active region, then the front porch. The period is set by a total register, so the period is active + front porch + back porch + 1.

Top module: `lcd_raster_timing`

## Requirements
- R1: The line period equals the horizontal total, written at word address 0 bits 15..0. The frame period equals that many clocks times the vertical total, written at address 0 bits 31..16.
- R2: The raw horizontal sync is active for exactly one clock, at horizontal count 0. The raw vertical sync is active for the whole of line 0.
- R3: Data-enable is raised when both of these hold: the horizontal count lies in [bp+1, bp+act] and below total−fp, and the vertical count meets the same condition using its own values. The active counts sit at address 1 (lines in 31..16, pixels in 15..0). Porch registers are at address 2 (horizontal) and address 3 (vertical). In each porch register the lower half holds bp, the porch between sync and the first active pixel. The upper half holds fp.
- R4: While data-enable is raised, pix_x and pix_y give the zero-based position inside the active window. Otherwise both are 0.
- R5: pix_rgb carries pix_in, sampled at the same edge, when data-enable is raised. Otherwise it carries the 24-bit blank colour at address 4.
- R6: Control bit 0 at address 5 enables the panel. While the panel is off, all counters and the frame count are 0, the syncs and data-enable sit at their inactive level, and panel_on is low. The clock after enabling from the off state, the scan stands at position (0,0).
- R7: frame_cnt increases by one at each wrap from the last position of a frame to (0,0).
- R8: While the panel runs, writes take effect only at the first clock of the next frame. This includes disabling the panel.
- R9: Control bit 2 inverts hsync, bit 3 inverts vsync and bit 4 inverts de. Bit 1 drives the pclk_inv output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| pix_in | input | 24 | Pixel colour from the pixel source |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data-enable after polarity |
| pix_x | output | 16 | Active pixel column |
| pix_y | output | 16 | Active line number |
| pix_rgb | output | 24 | Output colour |
| frame_cnt | output | 16 | Frames since enable |
| pclk_inv | output | 1 | Pixel clock inversion select |
| panel_on | output | 1 | Panel running |

## Verification
Every output is registered. After a clock edge, each output describes the scan position entered at that edge, and pix_rgb holds the pix_in value sampled at that edge. From the off state, a write to the enable bit is seen at the edge after the write cycle. While the panel runs, a write changes nothing until the edge that wraps the frame, and from that edge on every output follows the new settings. The bench's behavioural model takes the same inputs at each rising edge, and the outputs are compared with it at the following falling edge, so each result is checked in the cycle it is due. Period measurements on the sync outputs cover R1 independently of the model.

// File: rtl/lcd_rt_pkg.sv
package lcd_rt_pkg;
    localparam int CW   = 16;
    localparam int DW   = 2 * CW;
    localparam int RGBW = 24;
    localparam int AW   = 3;

    localparam logic [AW-1:0] A_TOTAL  = 3'd0;
    localparam logic [AW-1:0] A_ACTIVE = 3'd1;
    localparam logic [AW-1:0] A_HPORCH = 3'd2;
    localparam logic [AW-1:0] A_VPORCH = 3'd3;
    localparam logic [AW-1:0] A_BLANK  = 3'd4;
    localparam logic [AW-1:0] A_CTRL   = 3'd5;

    typedef struct packed {
        logic [CW-1:0]   v_tot;
        logic [CW-1:0]   h_tot;
        logic [CW-1:0]   v_act;
        logic [CW-1:0]   h_act;
        logic [CW-1:0]   v_back;
        logic [CW-1:0]   h_back;
        logic [CW-1:0]   v_front;
        logic [CW-1:0]   h_front;
        logic [RGBW-1:0] blank;
        logic            de_inv;
        logic            vs_inv;
        logic            hs_inv;
        logic            pclk_inv;
        logic            en;
    } cfg_t;

    function automatic cfg_t cfg_write(cfg_t c, logic [AW-1:0] a, logic [DW-1:0] w);
        cfg_t r;
        r = c;
        case (a)
            A_TOTAL:  begin r.v_tot   = w[DW-1:CW]; r.h_tot  = w[CW-1:0]; end
            A_ACTIVE: begin r.v_act   = w[DW-1:CW]; r.h_act  = w[CW-1:0]; end
            A_HPORCH: begin r.h_front = w[DW-1:CW]; r.h_back = w[CW-1:0]; end
            A_VPORCH: begin r.v_front = w[DW-1:CW]; r.v_back = w[CW-1:0]; end
            A_BLANK:  r.blank = w[RGBW-1:0];
            A_CTRL: begin
                r.en       = w[0];
                r.pclk_inv = w[1];
                r.hs_inv   = w[2];
                r.vs_inv   = w[3];
                r.de_inv   = w[4];
            end
            default: ;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/lcd_rt_cfg.sv
module lcd_rt_cfg
    import lcd_rt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    output cfg_t          live_o,
    output cfg_t          live_next_o
);
    typedef struct packed {
        cfg_t staged;
        cfg_t live;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.live = q.staged;
        end
        if (we) begin
            d.staged = cfg_write(q.staged, addr, wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign live_o      = q.live;
    assign live_next_o = d.live;
endmodule

// File: rtl/lcd_rt_axis.sv
module lcd_rt_axis #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] tot_q,
    input  logic [W-1:0] tot_n,
    input  logic [W-1:0] back_n,
    input  logic [W-1:0] act_n,
    input  logic [W-1:0] front_n,
    output logic [W-1:0] cnt_o,
    output logic         last_o,
    output logic         sync_o,
    output logic         act_o,
    output logic [W-1:0] coord_o
);
    localparam int XW = W + 1;

    logic [W-1:0]  cnt_q, cnt_d;
    logic [XW-1:0] start_x, end_act_x, end_fp_x, nxt_x;

    assign last_o = ({1'b0, cnt_q} + XW'(1)) >= {1'b0, tot_q};

    always_comb begin
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = last_o ? '0 : cnt_q + W'(1);
        end else begin
            cnt_d = cnt_q;
        end
        start_x   = {1'b0, back_n} + XW'(1);
        end_act_x = start_x + {1'b0, act_n};
        end_fp_x  = {1'b0, tot_n} - {1'b0, front_n};
        nxt_x     = {1'b0, cnt_d};
        sync_o    = (cnt_d == '0);
        act_o     = (nxt_x >= start_x) && (nxt_x < end_act_x) && (nxt_x < end_fp_x);
        coord_o   = cnt_d - start_x[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    AST_AXIS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && last_o) |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
    import lcd_rt_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [DW-1:0]      cfg_wdata,
    input  logic [RGBW-1:0]    pix_in,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [CW-1:0]      pix_x,
    output logic [CW-1:0]      pix_y,
    output logic [RGBW-1:0]    pix_rgb,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               pclk_inv,
    output logic               panel_on
);
    typedef struct packed {
        logic               running;
        logic               hs_raw;
        logic               vs_raw;
        logic               de_raw;
        logic               hsync;
        logic               vsync;
        logic               de;
        logic [CW-1:0]      pix_x;
        logic [CW-1:0]      pix_y;
        logic [RGBW-1:0]    rgb;
        logic [FRAME_W-1:0] frame;
    } st_t;

    st_t q, d;

    cfg_t          live_q, live_n;
    logic          h_last, v_last, h_sync, v_sync, h_act, v_act;
    logic [CW-1:0] h_cnt, v_cnt, h_coord, v_coord;
    logic          wrap, load, go, clr;

    assign wrap = q.running && h_last && v_last;
    assign load = !live_q.en || wrap;
    assign go   = live_n.en;
    assign clr  = !go || !q.running;

    lcd_rt_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .load        (load),
        .live_o      (live_q),
        .live_next_o (live_n)
    );

    lcd_rt_axis #(.W(CW)) u_hax (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .step    (1'b1),
        .tot_q   (live_q.h_tot),
        .tot_n   (live_n.h_tot),
        .back_n  (live_n.h_back),
        .act_n   (live_n.h_act),
        .front_n (live_n.h_front),
        .cnt_o   (h_cnt),
        .last_o  (h_last),
        .sync_o  (h_sync),
        .act_o   (h_act),
        .coord_o (h_coord)
    );

    lcd_rt_axis #(.W(CW)) u_vax (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .step    (h_last),
        .tot_q   (live_q.v_tot),
        .tot_n   (live_n.v_tot),
        .back_n  (live_n.v_back),
        .act_n   (live_n.v_act),
        .front_n (live_n.v_front),
        .cnt_o   (v_cnt),
        .last_o  (v_last),
        .sync_o  (v_sync),
        .act_o   (v_act),
        .coord_o (v_coord)
    );

    always_comb begin
        d = q;
        d.running = go;
        if (!go) begin
            d.frame = '0;
        end else if (wrap) begin
            d.frame = q.frame + FRAME_W'(1);
        end
        d.hs_raw = go && h_sync;
        d.vs_raw = go && v_sync;
        d.de_raw = go && h_act && v_act;
        d.hsync  = d.hs_raw ^ live_n.hs_inv;
        d.vsync  = d.vs_raw ^ live_n.vs_inv;
        d.de     = d.de_raw ^ live_n.de_inv;
        d.pix_x  = d.de_raw ? h_coord : '0;
        d.pix_y  = d.de_raw ? v_coord : '0;
        d.rgb    = d.de_raw ? pix_in : live_n.blank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hsync     = q.hsync;
    assign vsync     = q.vsync;
    assign de        = q.de;
    assign pix_x     = q.pix_x;
    assign pix_y     = q.pix_y;
    assign pix_rgb   = q.rgb;
    assign frame_cnt = q.frame;
    assign pclk_inv  = live_q.pclk_inv;
    assign panel_on  = q.running;

    AST_HSYNC_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hs_raw && live_q.h_tot > CW'(1)) |=> !q.hs_raw); // R2
    AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        q.de_raw |-> (!q.hs_raw && !q.vs_raw)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !q.running |-> (!q.hs_raw && !q.vs_raw && !q.de_raw && q.frame == '0)); // R6
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.running && $past(q.running)) |->
            (q.frame == $past(q.frame) || q.frame == $past(q.frame) + FRAME_W'(1))); // R7
    AST_CFG_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.running && $past(q.running) && (live_q != $past(live_q))) |->
            (h_cnt == '0 && v_cnt == '0)); // R8
endmodule

// File: tb/lcd_raster_timing_tb.sv
module lcd_raster_timing_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [23:0] pix_in = 24'h000000;
    logic        hsync, vsync, de, pclk_inv, panel_on;
    logic [15:0] pix_x, pix_y, frame_cnt;
    logic [23:0] pix_rgb;

    always #4 clk = ~clk;

    lcd_raster_timing u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_in(pix_in), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb),
        .frame_cnt(frame_cnt), .pclk_inv(pclk_inv), .panel_on(panel_on)
    );

    int nchk = 0;
    int nfail = 0;
    bit chk_on = 0;
    bit done = 0;
    bit measure = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [31:0] S [6];
    logic [31:0] L [6];
    int mh, mv, mframe;
    bit mrun;
    bit e_hs, e_vs, e_de, e_pclk, e_on;
    int e_x, e_y;
    logic [23:0] e_rgb;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (S[i]) begin S[i] = '0; L[i] = '0; end
            mh = 0; mv = 0; mframe = 0; mrun = 0;
            e_hs = 0; e_vs = 0; e_de = 0; e_pclk = 0; e_on = 0;
            e_x = 0; e_y = 0; e_rgb = '0;
        end else begin
            int ht, vt, hb, vb, ha, va, hf, vf;
            bit hl, vl, wrap, go, hin, vin, draw;
            ht = int'(L[0][15:0]); vt = int'(L[0][31:16]);
            hl = (mh + 1 >= ht); vl = (mv + 1 >= vt);
            wrap = mrun && hl && vl;
            if (!L[5][0] || wrap) foreach (L[i]) L[i] = S[i];
            if (cfg_we && cfg_addr < 3'd6) S[cfg_addr] = cfg_wdata;
            go = L[5][0];
            if (!go) begin
                mh = 0; mv = 0; mrun = 0; mframe = 0;
            end else if (!mrun) begin
                mh = 0; mv = 0; mrun = 1;
            end else begin
                if (wrap) mframe = (mframe + 1) & 16'hFFFF;
                if (hl) begin mh = 0; mv = vl ? 0 : mv + 1; end
                else mh = mh + 1;
            end
            ht = int'(L[0][15:0]); vt = int'(L[0][31:16]);
            ha = int'(L[1][15:0]); va = int'(L[1][31:16]);
            hb = int'(L[2][15:0]); hf = int'(L[2][31:16]);
            vb = int'(L[3][15:0]); vf = int'(L[3][31:16]);
            hin = (mh >= hb + 1) && (mh < hb + 1 + ha) && (mh < ht - hf);
            vin = (mv >= vb + 1) && (mv < vb + 1 + va) && (mv < vt - vf);
            draw = go && hin && vin;
            e_hs = (go && mh == 0) ^ L[5][2];
            e_vs = (go && mv == 0) ^ L[5][3];
            e_de = draw ^ L[5][4];
            e_x = draw ? mh - hb - 1 : 0;
            e_y = draw ? mv - vb - 1 : 0;
            e_rgb = draw ? pix_in : L[4][23:0];
            e_pclk = L[5][1];
            e_on = go;
        end
    end

    int hgap = 0, vgap = 0;
    bit hseen = 0, vseen = 0, hs_prev = 0, vs_prev = 0;

    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk(hsync == e_hs, "R2 hsync", hsync, e_hs);
            chk(vsync == e_vs, "R2 vsync", vsync, e_vs);
            chk(de == e_de, "R3,R9 de", de, e_de);
            chk(pix_x == 16'(e_x), "R4 pix_x", pix_x, e_x);
            chk(pix_y == 16'(e_y), "R4 pix_y", pix_y, e_y);
            chk(pix_rgb == e_rgb, "R5,R8 pix_rgb", pix_rgb, e_rgb);
            chk(frame_cnt == 16'(mframe), "R7 frame_cnt", frame_cnt, mframe);
            chk(pclk_inv == e_pclk, "R9 pclk_inv", pclk_inv, e_pclk);
            chk(panel_on == e_on, "R6 panel_on", panel_on, e_on);
            if (measure) begin
                hgap++; vgap++;
                if (hsync && !hs_prev) begin
                    if (hseen) chk(hgap == 8, "R1 line period", hgap, 8);
                    hseen = 1; hgap = 0;
                end
                if (vsync && !vs_prev) begin
                    if (vseen) chk(vgap == 48, "R1 frame period", vgap, 48);
                    vseen = 1; vgap = 0;
                end
            end
            hs_prev = hsync; vs_prev = vsync;
        end
    end

    always @(negedge clk) if (rst_n) pix_in <= pix_in + 24'h010203;

    task automatic wr(input logic [2:0] a, input logic [31:0] w);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        chk_on = 1;
        repeat (3) @(negedge clk);
        chk(panel_on == 1'b0 && frame_cnt == 16'd0 && hsync == 1'b0, "R6 reset state",
            {panel_on, frame_cnt}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // geometry: h 4+2+1+1=8, v 3+1+1+1=6
        wr(3'd0, {16'd6, 16'd8});
        wr(3'd1, {16'd3, 16'd4});
        wr(3'd2, {16'd2, 16'd1});
        wr(3'd3, {16'd1, 16'd1});
        wr(3'd4, 32'h00123456);
        wr(3'd5, 32'h1);
        measure = 1;
        repeat (150) @(negedge clk);
        measure = 0;
        // R8: mid-frame polarity and blank change, deferred to next frame
        repeat (5) @(negedge clk);
        wr(3'd4, 32'h00ABCDEF);
        wr(3'd5, 32'h1F);
        repeat (120) @(negedge clk);
        // new geometry: h 5+2+2+1=10, v 2+1+1+1=5
        wr(3'd0, {16'd5, 16'd10});
        wr(3'd1, {16'd2, 16'd5});
        wr(3'd2, {16'd2, 16'd2});
        wr(3'd3, {16'd1, 16'd1});
        wr(3'd5, 32'h1);
        repeat (150) @(negedge clk);
        // R6: disable lands at frame end, then restart
        wr(3'd5, 32'h0);
        repeat (100) @(negedge clk);
        wr(3'd5, 32'h1);
        repeat (60) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule